// File: doc/BRIEF.md
# Periodic Temperature Conversion Sequencer

This block decides when a temperature conversion runs and turns each finished sample into the 16-bit temperature result word. A conversion starts on its own right after reset. After that, conversions repeat at one of four rates picked by a two-bit rate code. Each conversion keeps the converter busy for a fixed number of ticks, and the block then waits for the rest of the period. All times are counted in ticks of a clock prescaler. The tick length, the busy time and the base slot are parameters, so a bench can run with short times.

When the shutdown input is set, the block finishes any conversion already running and then stops. While it is stopped, a one-shot write runs exactly one conversion and the block then stops again. The ready bit is low from the cycle a conversion starts until it ends, and high otherwise. The converter model returns a 13-bit two's-complement sample with a valid strobe at some point during the busy time. The block publishes that sample in either the 12-bit format or the 13-bit format, chosen by the extended-mode input. Bit 0 of the result tells which format is in use.

Top module: `conv_seq`

## Requirements
- R1: Reset values: the result is 0x0000 and the ready bit is 0. In the first clock cycle after reset is released, the block raises the start request. The result stays 0x0000 until that first conversion has completed.
- R2: A conversion is busy for exactly CONV_TICKS*PRESCALE cycles. The done strobe is a one-cycle pulse CONV_TICKS*PRESCALE cycles after the start pulse. The result register changes only in that done cycle.
- R3: The rate code sets the spacing between start pulses as SLOT_TICKS*PRESCALE cycles times a multiplier: code 00 gives 32, code 01 gives 8, code 10 gives 2 and code 11 gives 1.
- R4: A new rate code is sampled only when a conversion starts, so the period already running keeps its old length.
- R5: While shutdown is high, no new conversion starts after the current one finishes. Clearing shutdown while stopped starts a conversion in the next cycle.
- R6: A one-shot write with shutdown high while idle starts a conversion in the next cycle. After that conversion the block stays stopped.
- R7: The ready bit is 0 from the start pulse through the last busy cycle and 1 from the done cycle on, until the next start.
- R8: A one-shot write has no effect when shutdown is low. It also has no effect during a conversion: that conversion is not restarted, and no extra start follows.
- R9: Normal mode (extended input 0) result: the low 12 bits of the sample go in bits 15..4, and bits 3..0 are 0.
- R10: Extended mode result: the 13-bit sample goes in bits 15..3, bits 2..1 are 0 and bit 0 is 1.
- R11: The start request is a one-cycle pulse. The value published is the last sample that arrived with valid during the conversion. If no valid sample arrived, the block publishes the sample it held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 2 | Conversion rate code |
| shutdown | input | 1 | Stop after the current conversion |
| oneshot_wr | input | 1 | One-cycle one-shot write pulse |
| ext_mode | input | 1 | 1 selects the 13-bit result format |
| smp_data | input | 13 | Two's-complement sample from the converter |
| smp_valid | input | 1 | Sample strobe |
| conv_start | output | 1 | Start request pulse to the converter |
| conv_done | output | 1 | Result-updated pulse |
| temp_reg | output | 16 | Formatted temperature result |
| oneshot_rdy | output | 1 | 0 while converting, 1 otherwise |

## Verification
A one-shot write can arrive in the same cycle that a conversion is running. Both the bench and an assertion provoke this: the bench writes the one-shot bit two cycles into a one-shot conversion. The case is judged correct if the done strobe still comes exactly one busy time after the original start and no further start appears during the following 300 cycles. The bench also writes the one-shot bit during a period wait with shutdown low. That case is judged by the next start spacing, which must stay equal to the programmed period.

// File: rtl/conv_seq.sv
`timescale 1ns/1ps
module conv_seq #(
  parameter int PRESCALE   = 1000,
  parameter int CONV_TICKS = 26,
  parameter int SLOT_TICKS = 125
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  rate_sel,
  input  logic        shutdown,
  input  logic        oneshot_wr,
  input  logic        ext_mode,
  input  logic [12:0] smp_data,
  input  logic        smp_valid,
  output logic        conv_start,
  output logic        conv_done,
  output logic [15:0] temp_reg,
  output logic        oneshot_rdy
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int CW = $clog2(CONV_TICKS + 1);
  localparam int NW = $clog2(32 * SLOT_TICKS + 1);

  typedef enum logic [1:0] {S_BOOT, S_BUSY, S_WAIT, S_STOP} st_t;

  st_t          state, nxt;
  logic [PW-1:0] pre_cnt;
  logic [CW-1:0] conv_cnt;
  logic [NW-1:0] per_cnt, per_len;
  logic [1:0]    rate_q;
  logic [12:0]   hold_q, cap;
  logic          tick, conv_end, per_end, go;

  always_comb begin
    unique case (rate_q)
      2'b00:   per_len = NW'(32 * SLOT_TICKS);
      2'b01:   per_len = NW'(8 * SLOT_TICKS);
      2'b10:   per_len = NW'(2 * SLOT_TICKS);
      default: per_len = NW'(SLOT_TICKS);
    endcase
  end

  assign tick     = pre_cnt == PW'(PRESCALE - 1);
  assign conv_end = (state == S_BUSY) && tick && (conv_cnt == CW'(CONV_TICKS - 1));
  assign per_end  = (state == S_WAIT) && tick && (per_cnt == per_len - 1'b1);
  assign cap      = (smp_valid && state == S_BUSY) ? smp_data : hold_q;

  always_comb begin
    nxt = state;
    unique case (state)
      S_BOOT: nxt = S_BUSY;
      S_BUSY: if (conv_end) nxt = shutdown ? S_STOP : S_WAIT;
      S_WAIT: if ((shutdown && oneshot_wr) || (per_end && !shutdown)) nxt = S_BUSY;
              else if (per_end) nxt = S_STOP;
      S_STOP: if (!shutdown || oneshot_wr) nxt = S_BUSY;
    endcase
  end

  assign go          = (nxt == S_BUSY) && (state != S_BUSY);
  assign oneshot_rdy = (state == S_WAIT) || (state == S_STOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_BOOT;
      pre_cnt    <= '0;
      conv_cnt   <= '0;
      per_cnt    <= '0;
      rate_q     <= 2'b10;
      hold_q     <= '0;
      temp_reg   <= '0;
      conv_start <= 1'b0;
      conv_done  <= 1'b0;
    end else begin
      state      <= nxt;
      conv_start <= go;
      conv_done  <= conv_end;
      if (smp_valid && state == S_BUSY) hold_q <= smp_data;
      if (conv_end) temp_reg <= ext_mode ? {cap, 3'b001} : {cap[11:0], 4'h0};
      if (go) begin
        pre_cnt  <= '0;
        conv_cnt <= '0;
        per_cnt  <= '0;
        rate_q   <= rate_sel;
      end else if (state == S_BUSY || state == S_WAIT) begin
        pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
        if (tick) begin
          per_cnt <= per_cnt + 1'b1;
          if (state == S_BUSY) conv_cnt <= conv_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/conv_seq_chk.sv
`timescale 1ns/1ps
module conv_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        shutdown,
  input logic        oneshot_wr,
  input logic        ext_mode,
  input logic        conv_start,
  input logic        conv_done,
  input logic [15:0] temp_reg,
  input logic        oneshot_rdy
);
  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !oneshot_rdy);
  // R11
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !conv_done);
  // R7
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> oneshot_rdy);
  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |-> $stable(temp_reg));
  // R6
  sd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && $past(oneshot_rdy) && $past(shutdown)) |-> $past(oneshot_wr));
  // R5
  sd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oneshot_rdy && shutdown && !oneshot_wr) |=> !conv_start);
  // R10
  fmt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> (temp_reg[2:1] == 2'b00 && temp_reg[0] == $past(ext_mode)));
  // R9
  fmt_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !$past(ext_mode)) |-> temp_reg[3:0] == 4'h0);
endmodule

bind conv_seq conv_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .oneshot_wr(oneshot_wr),
  .ext_mode(ext_mode), .conv_start(conv_start), .conv_done(conv_done),
  .temp_reg(temp_reg), .oneshot_rdy(oneshot_rdy)
);

// File: tb/conv_seq_test.sv
`timescale 1ns/1ps
module conv_seq_test;
  localparam int BUSY = 6;
  logic clk = 0, rst_n = 0;
  logic [1:0] rate_sel = 2'b10;
  logic shutdown = 0, oneshot_wr = 0, ext_mode = 0, smp_valid = 0;
  logic [12:0] smp_data = '0;
  logic conv_start, conv_done, oneshot_rdy;
  logic [15:0] temp_reg;

  always #4 clk = ~clk;

  conv_seq #(.PRESCALE(2), .CONV_TICKS(3), .SLOT_TICKS(4)) uut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .shutdown(shutdown),
    .oneshot_wr(oneshot_wr), .ext_mode(ext_mode), .smp_data(smp_data),
    .smp_valid(smp_valid), .conv_start(conv_start), .conv_done(conv_done),
    .temp_reg(temp_reg), .oneshot_rdy(oneshot_rdy)
  );

  int cyc = 0, n_start = 0, n_done = 0, last_start = 0, prev_start = 0, last_done = 0;
  int fd = 0, checks = 0, fails = 0;
  logic feed_en = 1;
  logic [12:0] next_smp = '0;

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (conv_start) begin
      prev_start = last_start; last_start = cyc; n_start++; fd = 2;
    end
    if (conv_done) begin last_done = cyc; n_done++; end
    smp_valid = 0;
    if (fd > 0) begin
      fd--;
      if (fd == 0 && feed_en) begin smp_valid = 1; smp_data = next_smp; end
    end
    if (cyc >= 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      finish_run();
    end
  endtask

  task automatic wait_start();
    int n0 = n_start;
    for (int k = 0; k < 600 && n_start == n0; k++) step();
    if (n_start == n0) chk("R3", "start seen", 0, 1);
  endtask

  task automatic wait_done();
    int n0 = n_done;
    for (int k = 0; k < 600 && n_done == n0; k++) step();
    chk("R2", "busy length", last_done - last_start, BUSY);
  endtask

  task automatic t_reset();
    rst_n = 0; next_smp = 13'h0190;
    repeat (3) step();
    rst_n = 1;
    step();
    chk("R1", "start after reset", conv_start, 1);
    chk("R1", "reset result", temp_reg, 16'h0000);
    chk("R1", "reset ready", oneshot_rdy, 0);
    repeat (BUSY - 1) step();
    chk("R1", "result before first done", temp_reg, 16'h0000);
    chk("R7", "ready during busy", oneshot_rdy, 0);
    step();
    chk("R2", "done after busy", conv_done, 1);
    chk("R9", "first result", temp_reg, 16'h1900);
    chk("R7", "ready after done", oneshot_rdy, 1);
  endtask

  task automatic t_rates();
    wait_start(); chk("R3", "period code 10", last_start - prev_start, 16);
    repeat (3) step(); rate_sel = 2'b11;
    wait_start(); chk("R4", "old period kept", last_start - prev_start, 16);
    wait_start(); chk("R3", "period code 11", last_start - prev_start, 8);
    rate_sel = 2'b01;
    wait_start(); chk("R4", "old period kept 11", last_start - prev_start, 8);
    wait_start(); chk("R3", "period code 01", last_start - prev_start, 64);
    rate_sel = 2'b00;
    wait_start(); chk("R4", "old period kept 01", last_start - prev_start, 64);
    wait_start(); chk("R3", "period code 00", last_start - prev_start, 256);
    rate_sel = 2'b10;
    wait_start();
    wait_start(); chk("R3", "period back to 10", last_start - prev_start, 16);
  endtask

  task automatic t_format();
    next_smp = 13'h1C90; ext_mode = 0;
    wait_start(); wait_done(); chk("R9", "normal negative", temp_reg, 16'hC900);
    next_smp = 13'h1E70; ext_mode = 1;
    wait_start(); wait_done(); chk("R10", "extended negative", temp_reg, 16'hF381);
    next_smp = 13'h0960;
    wait_start(); wait_done(); chk("R10", "extended above 128", temp_reg, 16'h4B01);
    feed_en = 0; ext_mode = 0;
    wait_start(); wait_done(); chk("R11", "no sample keeps held value", temp_reg, 16'h9600);
    feed_en = 1;
  endtask

  task automatic t_shutdown();
    int n0;
    wait_start(); shutdown = 1;
    wait_done();
    n0 = n_start;
    repeat (300) step();
    chk("R5", "no start in shutdown", n_start, n0);
    chk("R7", "ready while stopped", oneshot_rdy, 1);
  endtask

  task automatic t_oneshot();
    int n0;
    next_smp = 13'h0004;
    oneshot_wr = 1; step(); oneshot_wr = 0;
    chk("R6", "one-shot start", conv_start, 1);
    chk("R7", "ready low at start", oneshot_rdy, 0);
    n0 = n_start;
    repeat (2) step();
    oneshot_wr = 1; step(); oneshot_wr = 0;
    wait_done();
    chk("R8", "one-shot mid conversion, done time", last_done - last_start, BUSY);
    chk("R9", "one-shot result", temp_reg, 16'h0040);
    repeat (300) step();
    chk("R6", "back to shutdown", n_start, n0);
    chk("R8", "write during busy gave no start", oneshot_rdy, 1);
  endtask

  task automatic t_resume();
    shutdown = 0; step();
    chk("R5", "start when shutdown cleared", conv_start, 1);
  endtask

  task automatic t_ignore();
    wait_done();
    oneshot_wr = 1; step(); oneshot_wr = 0;
    chk("R8", "one-shot ignored without shutdown", conv_start, 0);
    wait_start();
    chk("R8", "period unchanged", last_start - prev_start, 16);
  endtask

  initial begin
    t_reset();
    t_rates();
    t_format();
    t_shutdown();
    t_oneshot();
    t_resume();
    t_ignore();
    finish_run();
  end
endmodule